// File: doc/BRIEF.md
# Radio Baseband Pin Sequencer

This block sits between a baseband controller and an external radio chip and drives the pins that connect them. A free-running divider splits the 12 MHz baseband clock into bit periods of 12 clocks, which gives an air data rate of 1 Mbit/s. In transmit, the block presents one data bit per period on the air data line. In receive, it samples the incoming air line once per period, in the middle of the bit.

The synchronisation pin means different things in the two directions. In receive, it stays low while the correlator searches for the access code. It goes high when the correlator reports a lock and stays high until the packet ends or the direction changes. In transmit, it acts as the enable for the radio's transmitter output. The chip-enable pin passes on the controller's power request to the radio. During a power-down phase it is forced low, but only while hardware clock control is active. The sync and chip-enable pins stay undriven until their alternate-function bits are set. The air data line is high after reset.

Top module: `radio_pin_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it: air_out is 1, sync_out, sync_oe, ce_out and ce_oe are 0, and rx_vld is 0.
- R2: bit_tick pulses for exactly one clock every 12 clocks. A change of tx_mode restarts the divider, so the first bit_tick comes on the 12th clock after the edge that accepts the new mode.
- R3: In transmit (tx_mode=1), air_out takes the value of tx_bit on the edge that ends a bit_tick cycle and holds it for the following 12 clocks.
- R4: In receive (tx_mode=0), air_in is sampled on the edge that ends the 7th clock after a bit_tick clock, which is divider count 6. rx_bit shows the sample and rx_vld is 1 for the single clock after that edge. air_in values on other clocks of the bit are ignored.
- R5: In receive, air_out is held at 1.
- R6: In receive, sync_out stays 0 until corr_lock is seen high. It goes to 1 one clock later and stays 1 after corr_lock falls.
- R7: In receive, pkt_done drives sync_out to 0 one clock later and takes priority over corr_lock.
- R8: In transmit, sync_out follows tx_key with one clock of delay.
- R9: Any change of tx_mode drives sync_out to 0 on the next clock. After a return to receive, sync_out stays 0 until a new corr_lock arrives.
- R10: When no power-down is forced, ce_out follows ce_req with one clock of delay.
- R11: ce_out is 0 one clock after pd_req and hcc_en are both 1. pd_req with hcc_en=0 has no effect on ce_out.
- R12: sync_oe follows sync_alt_en, and ce_oe follows ce_alt_en, each with one clock of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Baseband clock (12 clocks per air bit) |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_mode | input | 1 | Direction: 1 transmit, 0 receive |
| corr_lock | input | 1 | Correlator reports access-code lock |
| pkt_done | input | 1 | Received packet has ended |
| tx_key | input | 1 | Request to enable the radio transmitter |
| tx_bit | input | 1 | Next transmit bit, loaded on bit_tick |
| air_in | input | 1 | Received air data from the radio |
| pd_req | input | 1 | Power-down phase active |
| hcc_en | input | 1 | Hardware clock control enabled |
| sync_alt_en | input | 1 | Alternate-function enable for the sync pin |
| ce_alt_en | input | 1 | Alternate-function enable for chip-enable |
| ce_req | input | 1 | Requested chip-enable level |
| air_out | output | 1 | Transmit air data line |
| bit_tick | output | 1 | One-clock strobe at the end of each bit period |
| rx_bit | output | 1 | Last sampled receive bit |
| rx_vld | output | 1 | rx_bit updated on the previous edge |
| sync_out | output | 1 | Sync pin level |
| sync_oe | output | 1 | Sync pin output enable (0 means tri-stated) |
| ce_out | output | 1 | Chip-enable pin level |
| ce_oe | output | 1 | Chip-enable output enable (0 means tri-stated) |

## Verification
Assertions check on every cycle that:
- the divider count stays in range and both strobes last one clock;
- air_out holds between bit strobes and stays high in receive;
- sync_out drops after a direction change or a packet end, and rises in receive only after a lock;
- chip-enable is low under a forced power-down.

Only the bench's scenarios can show the exact 12-clock spacing of the strobes and the 12-clock delay to the first strobe after a mode change. The same holds for the bit values that come out on air_out and rx_bit, the mid-bit sample point (shown with a one-clock glitch), and the fact that pd_req alone has no effect.

// File: rtl/rps_pkg.sv
package rps_pkg;

  typedef enum logic {
    RPS_RX = 1'b0,
    RPS_TX = 1'b1
  } rps_dir_e;

  // Width needed to count 0 .. n-1.
  function automatic int rps_cnt_width(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  // Chip-enable level: the request, overridden low by a power-down phase
  // only while hardware clock control is enabled.
  function automatic logic rps_ce_level(input logic req, input logic pd,
                                        input logic hcc);
    return req & ~(pd & hcc);
  endfunction

  // Receive sync level: a packet end clears, a lock sets, otherwise hold.
  function automatic logic rps_rx_sync(input logic cur, input logic lock,
                                       input logic done);
    return ~done & (cur | lock);
  endfunction

endpackage

// File: rtl/rps_bit_timer.sv
module rps_bit_timer #(
  parameter int CLKS_PER_BIT = 12,
  parameter int SAMPLE_AT    = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic bit_stb,
  output logic smp_stb
);
  import rps_pkg::*;

  localparam int CW = rps_cnt_width(CLKS_PER_BIT);
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);
  localparam logic [CW-1:0] SMP  = CW'(SAMPLE_AT);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign bit_stb = at_last & ~restart;
  assign smp_stb = (cnt_q == SMP) & ~restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (restart)    cnt_q <= '0;
    else if (at_last)    cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(CLKS_PER_BIT));

  assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |=> !bit_stb);

  assert_smp_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> !smp_stb);

endmodule

// File: rtl/rps_air_path.sv
module rps_air_path (
  input  logic clk,
  input  logic rst_n,
  input  logic dir_tx,
  input  logic restart,
  input  logic bit_stb,
  input  logic smp_stb,
  input  logic tx_bit,
  input  logic air_in,
  output logic air_out,
  output logic rx_bit,
  output logic rx_vld
);
  logic air_q, rxb_q, rxv_q;
  logic take_rx;

  assign take_rx = ~dir_tx & ~restart & smp_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        air_q <= 1'b1;
    else if (!dir_tx)  air_q <= 1'b1;
    else if (bit_stb)  air_q <= tx_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxb_q <= 1'b0;
      rxv_q <= 1'b0;
    end else begin
      rxv_q <= take_rx;
      if (take_rx) rxb_q <= air_in;
    end
  end

  assign air_out = air_q;
  assign rx_bit  = rxb_q;
  assign rx_vld  = rxv_q;

  assert_air_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dir_tx) && !$past(bit_stb)) |-> $stable(air_out));

  assert_air_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(dir_tx) |-> air_out);

  assert_rx_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_vld |=> !rx_vld);

endmodule

// File: rtl/rps_sync_ctl.sv
module rps_sync_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic dir_tx,
  input  logic restart,
  input  logic corr_lock,
  input  logic pkt_done,
  input  logic tx_key,
  input  logic alt_en,
  output logic sync_out,
  output logic sync_oe
);
  import rps_pkg::*;

  logic sync_q, oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sync_q <= 1'b0;
    else if (restart)  sync_q <= 1'b0;
    else if (dir_tx)   sync_q <= tx_key;
    else               sync_q <= rps_rx_sync(sync_q, corr_lock, pkt_done);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_q <= 1'b0;
    else        oe_q <= alt_en;
  end

  assign sync_out = sync_q;
  assign sync_oe  = oe_q;

  assert_sync_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(restart) |-> !sync_out);

  assert_sync_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(dir_tx) && !$past(restart) && !$past(sync_out) && sync_out)
      |-> $past(corr_lock));

  assert_sync_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(dir_tx) && $past(pkt_done)) |-> !sync_out);

endmodule

// File: rtl/rps_ce_ctl.sv
module rps_ce_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_req,
  input  logic pd_req,
  input  logic hcc_en,
  input  logic alt_en,
  output logic ce_out,
  output logic ce_oe
);
  import rps_pkg::*;

  logic ce_q, oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q <= 1'b0;
      oe_q <= 1'b0;
    end else begin
      ce_q <= rps_ce_level(ce_req, pd_req, hcc_en);
      oe_q <= alt_en;
    end
  end

  assign ce_out = ce_q;
  assign ce_oe  = oe_q;

  assert_ce_force_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pd_req && hcc_en) |-> !ce_out);

endmodule

// File: rtl/radio_pin_seq.sv
module radio_pin_seq #(
  parameter int CLKS_PER_BIT = 12,
  parameter int SAMPLE_AT    = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_mode,
  input  logic corr_lock,
  input  logic pkt_done,
  input  logic tx_key,
  input  logic tx_bit,
  input  logic air_in,
  input  logic pd_req,
  input  logic hcc_en,
  input  logic sync_alt_en,
  input  logic ce_alt_en,
  input  logic ce_req,
  output logic air_out,
  output logic bit_tick,
  output logic rx_bit,
  output logic rx_vld,
  output logic sync_out,
  output logic sync_oe,
  output logic ce_out,
  output logic ce_oe
);
  import rps_pkg::*;

  rps_dir_e dir_q;
  logic     dir_tx;
  logic     mode_chg;
  logic     bit_stb, smp_stb;

  assign dir_tx   = (dir_q == RPS_TX);
  assign mode_chg = (tx_mode != dir_tx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dir_q <= RPS_RX;
    else if (mode_chg) dir_q <= tx_mode ? RPS_TX : RPS_RX;
  end

  rps_bit_timer #(
    .CLKS_PER_BIT(CLKS_PER_BIT),
    .SAMPLE_AT   (SAMPLE_AT)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(mode_chg),
    .bit_stb(bit_stb),
    .smp_stb(smp_stb)
  );

  rps_air_path u_air (
    .clk    (clk),
    .rst_n  (rst_n),
    .dir_tx (dir_tx),
    .restart(mode_chg),
    .bit_stb(bit_stb),
    .smp_stb(smp_stb),
    .tx_bit (tx_bit),
    .air_in (air_in),
    .air_out(air_out),
    .rx_bit (rx_bit),
    .rx_vld (rx_vld)
  );

  rps_sync_ctl u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .dir_tx   (dir_tx),
    .restart  (mode_chg),
    .corr_lock(corr_lock),
    .pkt_done (pkt_done),
    .tx_key   (tx_key),
    .alt_en   (sync_alt_en),
    .sync_out (sync_out),
    .sync_oe  (sync_oe)
  );

  rps_ce_ctl u_ce (
    .clk   (clk),
    .rst_n (rst_n),
    .ce_req(ce_req),
    .pd_req(pd_req),
    .hcc_en(hcc_en),
    .alt_en(ce_alt_en),
    .ce_out(ce_out),
    .ce_oe (ce_oe)
  );

  assign bit_tick = bit_stb;

  assert_mode_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> !bit_tick);

endmodule

// File: tb/sim_radio_pin_seq.sv
module sim_radio_pin_seq;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_mode = 0, corr_lock = 0, pkt_done = 0, tx_key = 0, tx_bit = 0;
  logic air_in = 0, pd_req = 0, hcc_en = 0, sync_alt_en = 0, ce_alt_en = 0;
  logic ce_req = 0;
  logic air_out, bit_tick, rx_bit, rx_vld, sync_out, sync_oe, ce_out, ce_oe;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic exp_tx[$];
  logic exp_rx[$];
  logic prev_tick = 0;

  always #10 clk = ~clk;

  radio_pin_seq u0 (
    .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .corr_lock(corr_lock),
    .pkt_done(pkt_done), .tx_key(tx_key), .tx_bit(tx_bit), .air_in(air_in),
    .pd_req(pd_req), .hcc_en(hcc_en), .sync_alt_en(sync_alt_en),
    .ce_alt_en(ce_alt_en), .ce_req(ce_req), .air_out(air_out),
    .bit_tick(bit_tick), .rx_bit(rx_bit), .rx_vld(rx_vld),
    .sync_out(sync_out), .sync_oe(sync_oe), .ce_out(ce_out), .ce_oe(ce_oe)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (!bit_tick);
  endtask

  // Monitor: compare scoreboard items as results appear.
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_tick && tx_mode && exp_tx.size() > 0)
        check("R3 air_out", air_out, exp_tx.pop_front());
      if (rx_vld && exp_rx.size() > 0)
        check("R4 rx_bit", rx_bit, exp_rx.pop_front());
      prev_tick = bit_tick;
    end
  end

  // Drivers
  task automatic send_tx(input logic [7:0] pat);
    for (int i = 0; i < 8; i++) begin
      wait_tick();
      tx_bit = pat[i];
      exp_tx.push_back(pat[i]);
    end
    step(1);
  endtask

  task automatic send_rx(input logic [7:0] pat);
    for (int i = 0; i < 8; i++) begin
      wait_tick();
      air_in = pat[i];
      exp_rx.push_back(pat[i]);
    end
    step(9);
  endtask

  task automatic glitch_rx(input logic d);
    wait_tick();
    air_in = ~d;
    exp_rx.push_back(d);
    step(7);
    air_in = d;
    step(1);
    air_in = ~d;
    step(2);
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          n_bad++; n_cmp++;
          $display("FAIL watchdog: got timeout expected completion");
          $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
          $finish;
        end
      end
    join_none

    // R1 reset state
    step(3);
    check("R1 air_out", air_out, 1'b1);
    check("R1 sync_out", sync_out, 1'b0);
    check("R1 sync_oe", sync_oe, 1'b0);
    check("R1 ce_out", ce_out, 1'b0);
    check("R1 ce_oe", ce_oe, 1'b0);
    check("R1 rx_vld", rx_vld, 1'b0);
    rst_n = 1'b1;
    step(1);
    check("R1 air_out after", air_out, 1'b1);
    check("R1 sync_oe after", sync_oe, 1'b0);

    // R12 output enables
    sync_alt_en = 1; ce_alt_en = 1;
    check("R12 sync_oe before", sync_oe, 1'b0);
    step(1);
    check("R12 sync_oe", sync_oe, 1'b1);
    check("R12 ce_oe", ce_oe, 1'b1);
    ce_alt_en = 0;
    step(1);
    check("R12 ce_oe off", ce_oe, 1'b0);
    ce_alt_en = 1;

    // R6 / R7 receive sync
    step(3);
    check("R6 sync low before lock", sync_out, 1'b0);
    corr_lock = 1;
    step(1);
    check("R6 sync high after lock", sync_out, 1'b1);
    corr_lock = 0;
    step(4);
    check("R6 sync held", sync_out, 1'b1);
    pkt_done = 1; corr_lock = 1;
    step(1);
    check("R7 sync cleared by pkt_done", sync_out, 1'b0);
    pkt_done = 0; corr_lock = 0;
    step(2);
    check("R7 sync stays low", sync_out, 1'b0);

    // R5 air idle in receive
    check("R5 air_out high in rx", air_out, 1'b1);

    // R9 / R2 mode change to transmit
    corr_lock = 1; step(1); corr_lock = 0;
    check("R9 sync high in rx", sync_out, 1'b1);
    tx_mode = 1; tx_key = 1;
    begin
      int k = 0;
      do begin @(negedge clk); k++; end while (!bit_tick && k < 40);
      check("R2 first tick at 12", logic'(k == 12), 1'b1);
    end
    begin
      int k = 0;
      do begin @(negedge clk); k++; end while (!bit_tick && k < 40);
      check("R2 tick period 12", logic'(k == 12), 1'b1);
    end
    check("R8 sync follows tx_key", sync_out, 1'b1);
    tx_key = 0;
    step(1);
    check("R8 sync drops with tx_key", sync_out, 1'b0);
    tx_key = 1;
    step(1);
    check("R8 sync rises with tx_key", sync_out, 1'b1);

    // R3 transmit data
    send_tx(8'b1011_0010);
    send_tx(8'b0110_1101);
    step(5);
    check("R3 hold mid-bit", air_out, 1'b0);

    // R9 back to receive: sync cleared, correlation restarts
    tx_mode = 0; tx_key = 0;
    step(1);
    check("R9 sync cleared on mode change", sync_out, 1'b0);
    step(5);
    check("R9 sync waits for new lock", sync_out, 1'b0);
    check("R5 air_out back high", air_out, 1'b1);

    // R4 receive sampling
    send_rx(8'b1100_1010);
    glitch_rx(1'b1);
    glitch_rx(1'b0);
    step(12);

    // R10 / R11 chip-enable
    ce_req = 1;
    step(1);
    check("R10 ce follows req", ce_out, 1'b1);
    pd_req = 1; hcc_en = 0;
    step(2);
    check("R11 pd alone no effect", ce_out, 1'b1);
    hcc_en = 1;
    step(1);
    check("R11 ce forced low", ce_out, 1'b0);
    pd_req = 0;
    step(1);
    check("R10 ce restored", ce_out, 1'b1);
    ce_req = 0;
    step(1);
    check("R10 ce low on req", ce_out, 1'b0);

    if (exp_tx.size() != 0 || exp_rx.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R3/R4 scoreboard: got %0d left expected 0",
               exp_tx.size() + exp_rx.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule